// File: doc/BRIEF.md
# Flow-Gated Serial Transmitter

This block is the transmit half of an asynchronous serial port. A host writes bytes into a 16-entry queue. The block takes them out one at a time and shifts each onto a single output line as a frame: one start bit, eight data bits, one stop bit, no parity. The bit timing comes from an input strobe that pulses sixteen times per bit period. The block does not generate that strobe itself.

When flow gating is switched on, an active-low clear-to-send input decides whether the next queued byte may leave. The input is sampled once per frame, at the eighth strobe of the stop bit. That sample governs only the byte that follows. A frame that has already started always runs to its stop bit. When the line is idle, a low clear-to-send starts the queued bytes again. While gating is on, the block also raises a flag telling the host's interrupt logic to ignore clear-to-send edges.

Top module: `cts_gated_uart_tx`

## Requirements
- R1: The line idles high. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. Each bit lasts 16 strobes of `tick16`.
- R2: The queue holds 16 bytes. After reset `fifo_empty`=1 and `fifo_full`=0. `fifo_full` reads 1 exactly when 16 bytes are waiting, and the two flags are never 1 together.
- R3: A write while `fifo_full`=1 is dropped. That byte is never sent, and the bytes already queued go out unchanged.
- R4: With `flow_en`=1 and `cts_n`=1 (after synchronization), no new frame starts from an idle line.
- R5: A frame that has begun always completes through its stop bit, whatever `cts_n` does.
- R6: `cts_n` is latched at the eighth strobe of each stop bit. High at that point holds the next byte. A rise after that point still lets the next byte go and holds the byte after it.
- R7: With `flow_en`=1, when `cts_n` returns low, queued bytes resume.
- R8: With `flow_en`=0, every queued byte is sent whatever the level of `cts_n`.
- R9: `mode_aux` has no effect on transmission. Gating depends on `flow_en` alone.
- R10: `msr_irq_mask` equals 1 whenever `flow_en`=1 and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe into the queue |
| wr_data | input | 8 | Byte to queue |
| flow_en | input | 1 | Enables clear-to-send gating |
| mode_aux | input | 1 | Companion mode bit, unused by this path |
| cts_n | input | 1 | Active-low clear-to-send, asynchronous |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| txd | output | 1 | Serial output line |
| fifo_empty | output | 1 | Queue holds no bytes |
| fifo_full | output | 1 | Queue holds 16 bytes |
| msr_irq_mask | output | 1 | Suppress interrupts from clear-to-send changes |

## Verification
The checker assumes that `tick16` is a single-cycle pulse separated by idle cycles, and that `flow_en` does not change during a frame whose start it gates. The bench generates the strobe every fourth clock and changes `flow_en` only while the line is idle. It moves `cts_n` at chosen offsets inside a frame: mid-data, before the stop-bit latch point, and after it. It never lets a write and a full-queue condition meet a read in the same cycle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] bits;
        logic              valid;
    } tx_byte_t;

    // A new byte may leave when gating is off, or when clear-to-send is low.
    function automatic logic send_allowed(input logic gate_on, input logic cts_sync_n);
        return !gate_on || !cts_sync_n;
    endfunction

endpackage

// File: rtl/tx_byte_queue.sv
module tx_byte_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_req,
    input  logic [W-1:0] push_data,
    input  logic         pop_req,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push_req && !full;
    assign do_pop  = pop_req && !empty;
    assign head    = store[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) store[wp_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/cts_synchronizer.sv
module cts_synchronizer #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
    import uart_tx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         gate_on,
    input  logic         cts_s,
    input  logic         q_empty,
    input  logic [W-1:0] q_head,
    output logic         q_pop,
    output logic         line,
    output tx_state_e    state
);
    localparam int TW = $clog2(OVS);
    localparam int BW = $clog2(W);
    localparam logic [TW-1:0] LAST = TW'(OVS - 1);
    localparam logic [TW-1:0] MID  = TW'(OVS / 2 - 1);
    localparam logic [BW-1:0] TOPB = BW'(W - 1);

    tx_state_e     st_q;
    logic [TW-1:0] tcnt_q;
    logic [BW-1:0] bidx_q;
    logic [W-1:0]  sh_q;
    logic          line_q;
    logic          permit_q;
    logic          go_idle, go_chain, launch;

    assign go_idle  = (st_q == TX_IDLE) && send_allowed(gate_on, cts_s);
    assign go_chain = (st_q == TX_STOP) && (tcnt_q == LAST) && permit_q;
    assign launch   = tick && !q_empty && (go_idle || go_chain);
    assign q_pop    = launch;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= TX_IDLE;
            tcnt_q   <= '0;
            bidx_q   <= '0;
            sh_q     <= '0;
            line_q   <= 1'b1;
            permit_q <= 1'b0;
        end else if (launch) begin
            st_q   <= TX_START;
            sh_q   <= q_head;
            line_q <= 1'b0;
            tcnt_q <= '0;
        end else if (tick) begin
            case (st_q)
                TX_IDLE: tcnt_q <= '0;
                TX_START: begin
                    if (tcnt_q == LAST) begin
                        st_q   <= TX_DATA;
                        tcnt_q <= '0;
                        bidx_q <= '0;
                        line_q <= sh_q[0];
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                TX_DATA: begin
                    if (tcnt_q == LAST) begin
                        tcnt_q <= '0;
                        if (bidx_q == TOPB) begin
                            st_q   <= TX_STOP;
                            line_q <= 1'b1;
                        end else begin
                            bidx_q <= bidx_q + 1'b1;
                            sh_q   <= sh_q >> 1;
                            line_q <= sh_q[1];
                        end
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                TX_STOP: begin
                    if (tcnt_q == MID) permit_q <= send_allowed(gate_on, cts_s);
                    if (tcnt_q == LAST) begin
                        st_q   <= TX_IDLE;
                        tcnt_q <= '0;
                    end else begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                default: st_q <= TX_IDLE;
            endcase
        end
    end

    assign line  = line_q;
    assign state = st_q;
endmodule

// File: rtl/cts_gated_uart_tx.sv
module cts_gated_uart_tx
    import uart_tx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flow_en,
    input  logic              mode_aux,
    input  logic              cts_n,
    input  logic              tick16,
    output logic              txd,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              msr_irq_mask
);
    logic              cts_s;
    logic              pop;
    logic [DATA_W-1:0] head;
    tx_state_e         st;
    tx_byte_t          unused_aux;

    // mode_aux only matters to a receive-side block; kept for interface parity.
    assign unused_aux = '{bits: '0, valid: mode_aux};

    tx_byte_queue #(.DEPTH(DEPTH), .W(DATA_W)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push_req  (wr_en),
        .push_data (wr_data),
        .pop_req   (pop),
        .head      (head),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    cts_synchronizer #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (cts_n),
        .sync_out (cts_s)
    );

    frame_shifter #(.OVS(OVS), .W(DATA_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .gate_on (flow_en),
        .cts_s   (cts_s),
        .q_empty (fifo_empty),
        .q_head  (head),
        .q_pop   (pop),
        .line    (txd),
        .state   (st)
    );

    assign msr_irq_mask = flow_en;
endmodule

// File: rtl/cts_gated_uart_tx_chk.sv
module cts_gated_uart_tx_chk
    import uart_tx_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      wr_en,
    input logic      fifo_full,
    input logic      fifo_empty,
    input logic      flow_en,
    input logic      cts_s,
    input logic      pop,
    input logic      txd,
    input tx_state_e st
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty)); // R2

    AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && wr_en && !pop) |=> fifo_full); // R3

    AST_GATED_NO_START: assert property (@(posedge clk) disable iff (rst)
        (st == TX_START && $past(st) == TX_IDLE && $past(flow_en)) |-> !$past(cts_s)); // R4

    AST_FRAME_NOT_ABORTED: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == TX_DATA && st != TX_DATA) |-> st == TX_STOP); // R5

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (st == TX_IDLE || st == TX_STOP) |-> txd); // R1

    AST_START_LINE_LOW: assert property (@(posedge clk) disable iff (rst)
        (st == TX_START) |-> !txd); // R1
endmodule

bind cts_gated_uart_tx cts_gated_uart_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .flow_en    (flow_en),
    .cts_s      (cts_s),
    .pop        (pop),
    .txd        (txd),
    .st         (st)
);

// File: tb/cts_gated_uart_tx_bench.sv
module cts_gated_uart_tx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       flow_en = 1'b0;
    logic       mode_aux = 1'b0;
    logic       cts_n = 1'b1;
    logic       tick16 = 1'b0;
    logic       txd, fifo_empty, fifo_full, msr_irq_mask;

    int n_chk = 0, n_fail = 0;
    int rx_count = 0, rx_starts = 0;
    bit done = 0;
    logic [7:0] exp_q [$];
    logic [1:0] div = '0;

    always #10 clk = ~clk; // 50 MHz

    always @(posedge clk) begin
        div    <= div + 1'b1;
        tick16 <= (div == 2'd3);
    end

    cts_gated_uart_tx u_cts_gated_uart_tx (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .flow_en(flow_en), .mode_aux(mode_aux), .cts_n(cts_n), .tick16(tick16),
        .txd(txd), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .msr_irq_mask(msr_irq_mask)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, input bit kept);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        if (kept) exp_q.push_back(b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Monitor: decodes frames at mid-bit and scores them against the queue (R1).
    initial begin
        logic [7:0] b;
        logic [7:0] e;
        forever begin
            @(negedge clk);
            if (!rst && txd === 1'b0) begin
                rx_starts++;
                repeat (32) @(negedge clk);
                chk(txd == 1'b0, "R1 start bit", txd, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (64) @(negedge clk);
                    b[i] = txd;
                end
                repeat (64) @(negedge clk);
                chk(txd == 1'b1, "R1 stop bit", txd, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected byte", b, -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(b == e, "R1 byte", b, e);
                end
                rx_count++;
            end
        end
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R1 idle", txd, 1);
        chk(fifo_empty == 1'b1, "R2 empty", fifo_empty, 1);
        chk(fifo_full == 1'b0, "R2 full", fifo_full, 0);
        chk(msr_irq_mask == 1'b0, "R10 off", msr_irq_mask, 0);

        // R8: gating off, CTS high, aux set: all bytes leave.
        mode_aux = 1'b1; cts_n = 1'b1;
        wr_byte(8'hA5, 1); wr_byte(8'h01, 1); wr_byte(8'h80, 1);
        wait (rx_count == 3);
        chk(rx_count == 3, "R8 sent", rx_count, 3);
        repeat (100) @(negedge clk);

        // R4/R9/R2/R3: gating on with aux low, CTS high: fill and hold.
        flow_en = 1'b1; mode_aux = 1'b0;
        repeat (10) @(negedge clk);
        chk(msr_irq_mask == 1'b1, "R10 on", msr_irq_mask, 1);
        base = rx_count;
        for (int i = 0; i < 16; i++) wr_byte(8'(i * 37 + 5), 1);
        chk(fifo_full == 1'b1, "R2 full at 16", fifo_full, 1);
        wr_byte(8'hEE, 0);
        chk(fifo_full == 1'b1, "R3 still full", fifo_full, 1);
        repeat (2000) @(negedge clk);
        chk(rx_count == base, "R4 held", rx_count, base);
        chk(txd == 1'b1, "R9 line idle", txd, 1);
        cts_n = 1'b0;
        wait (rx_count == base + 16);
        repeat (1000) @(negedge clk);
        chk(rx_count == base + 16, "R3 dropped byte unsent", rx_count, base + 16);
        chk(fifo_empty == 1'b1, "R7 drained", fifo_empty, 1);

        // R5/R6 early rise: during data bits of first byte.
        cts_n = 1'b1;
        repeat (10) @(negedge clk);
        base = rx_count;
        wr_byte(8'h3C, 1); wr_byte(8'hC3, 1); wr_byte(8'h5A, 1);
        cts_n = 1'b0;
        wait (rx_starts == base + 1);
        repeat (200) @(negedge clk);
        cts_n = 1'b1;
        wait (rx_count == base + 1);
        repeat (2000) @(negedge clk);
        chk(rx_count == base + 1, "R5 R6 early rise holds next", rx_count, base + 1);
        cts_n = 1'b0;
        wait (rx_count == base + 3);
        chk(rx_count == base + 3, "R7 resume", rx_count, base + 3);
        repeat (100) @(negedge clk);

        // R6 late rise: after stop-bit latch point, next byte still goes.
        cts_n = 1'b1;
        repeat (10) @(negedge clk);
        base = rx_count;
        wr_byte(8'h11, 1); wr_byte(8'h22, 1); wr_byte(8'h33, 1);
        cts_n = 1'b0;
        wait (rx_starts == base + 1);
        repeat (620) @(negedge clk);
        cts_n = 1'b1;
        wait (rx_count == base + 2);
        repeat (2000) @(negedge clk);
        chk(rx_count == base + 2, "R6 late rise", rx_count, base + 2);
        cts_n = 1'b0;
        wait (rx_count == base + 3);
        repeat (100) @(negedge clk);

        flow_en = 1'b0;
        @(negedge clk);
        chk(msr_irq_mask == 1'b0, "R10 off again", msr_irq_mask, 0);
        chk(exp_q.size() == 0, "R1 all bytes seen", exp_q.size(), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule